// File: doc/BRIEF.md
# I2S Slave Frame-Sync Guard

This block sits in front of the serial data path of an I2S slave. It follows the word-select line, sampled on each rising serial clock, and decides when the slave may treat incoming bits as framed audio. After an enable, it first waits for word select to rest at the idle level of the chosen audio standard. It then takes the next change of word select as the start of a half-frame. Once locked, it counts serial clocks between word-select changes and raises a frame error whenever a change lands at a position other than the configured channel length.

The block also holds the status flags seen by software: transmit empty, receive not empty, underrun, overrun and frame error. It merges them with per-source enables into one registered, level-high interrupt. Register decoding is reduced to a status-read strobe and data-access strobes. Serial shifting, DMA and any data checksum are outside the block. Lost sync is never repaired while the block stays enabled. Software recovers by clearing the enable and setting it again.

Top module: `i2s_sync_guard`

## Requirements
- R1: While enabled and not locked, the block locks (`locked_o`=1) only after it sees a serial-clock sample with word select at the idle level and, later, a serial-clock sample with word select away from it. The idle level is high for `std_i`=00 (Philips) and low for 01 (MSB-justified), 10 (LSB-justified) and 11 (PCM). The first sample after the enable rises is not used.
- R2: With `en_i` low, `locked_o` is 0 on the next clock. No relock or resync happens while `en_i` stays high. After a frame error the block stays locked.
- R3: While locked, a word-select change at a serial-clock sample sets `fre_o` on the next clock unless exactly N samples were counted since the previous change, the change sample included as 1. N is 32 when `chlen32_i`=1 and 16 otherwise.
- R4: A `stat_rd_i` strobe clears `fre_o` on the next clock, unless a new frame error is detected in the same cycle, in which case the flag stays set.
- R5: `txe_o` is 1 after reset. `tx_load_i` clears it, and this takes precedence. `tx_take_i` sets it.
- R6: `rxne_o` is 0 after reset. `rx_push_i` sets it, and this takes precedence. `rx_read_i` clears it.
- R7: `tx_take_i` while `txe_o`=1 sets `udr_o`. The flag is cleared only by a `tx_load_i` that comes after a `stat_rd_i` made while `udr_o` was set. A new underrun cancels a pending clear.
- R8: `rx_push_i` while `rxne_o`=1 sets `ovr_o`. The flag is cleared only by an `rx_read_i` that comes after a `stat_rd_i` made while `ovr_o` was set. A new overrun cancels a pending clear.
- R9: `irq_o` equals, one clock later, the OR of `txe_o`&`ie_txe_i`, `rxne_o`&`ie_rxne_i`, and (`ovr_o`|`udr_o`|`fre_o`)&`ie_err_i`.
- R10: Word-select activity while not locked never sets `fre_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| std_i | input | 2 | Audio standard: 00 Philips, 01 MSB, 10 LSB, 11 PCM |
| chlen32_i | input | 1 | Channel length 32 (1) or 16 (0) |
| sck_rise_i | input | 1 | One-cycle pulse per serial-clock rising edge |
| ws_i | input | 1 | Word-select level, synchronized |
| tx_load_i | input | 1 | Software wrote transmit data |
| tx_take_i | input | 1 | Shifter took a transmit word |
| rx_push_i | input | 1 | Shifter delivered a receive word |
| rx_read_i | input | 1 | Software read receive data |
| stat_rd_i | input | 1 | Status register read strobe |
| ie_txe_i | input | 1 | Transmit-empty interrupt enable |
| ie_rxne_i | input | 1 | Receive-not-empty interrupt enable |
| ie_err_i | input | 1 | Shared error interrupt enable |
| locked_o | output | 1 | Frame sync acquired |
| txe_o | output | 1 | Transmit empty |
| rxne_o | output | 1 | Receive not empty |
| udr_o | output | 1 | Underrun |
| ovr_o | output | 1 | Overrun |
| fre_o | output | 1 | Frame error |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The assertions assume that `sck_rise_i` and `ws_i` are already synchronized to the system clock. They also assume that a word-select level is only meaningful in a cycle where `sck_rise_i` is high. The bench drives all inputs on the falling clock edge, so each strobe is seen at exactly one rising edge. Serial-clock pulses are spaced at least one idle cycle apart in the directed phases. The random phase then deliberately allows strobe collisions, so that every stated precedence rule is exercised.

// File: rtl/i2s_guard_pkg.sv
package i2s_guard_pkg;
  typedef enum logic [1:0] {
    STD_PHILIPS = 2'b00,
    STD_MSB     = 2'b01,
    STD_LSB     = 2'b10,
    STD_PCM     = 2'b11
  } std_e;

  typedef enum logic [1:0] {
    TRK_OFF,
    TRK_WAIT,
    TRK_ARMED,
    TRK_LOCK
  } trk_e;
endpackage

// File: rtl/i2s_ws_tracker.sv
module i2s_ws_tracker
  import i2s_guard_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] std_i,
  input  logic       chlen32_i,
  input  logic       sck_rise_i,
  input  logic       ws_i,
  output logic       locked_o,
  output logic       frame_err_o
);
  localparam logic [CNT_W-1:0] LEN_S   = CNT_W'(SHORT_LEN);
  localparam logic [CNT_W-1:0] LEN_L   = CNT_W'(LONG_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  trk_e             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prev_q;
  logic             idle_lvl;
  logic             ws_chg;
  logic [CNT_W-1:0] len_sel;

  assign idle_lvl = (std_e'(std_i) == STD_PHILIPS);
  assign len_sel  = chlen32_i ? LEN_L : LEN_S;
  assign ws_chg   = sck_rise_i && (ws_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TRK_OFF;
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else if (!en_i) begin
      st_q  <= TRK_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        TRK_OFF:   st_q <= TRK_WAIT;
        TRK_WAIT:  if (sck_rise_i && ws_i == idle_lvl) st_q <= TRK_ARMED;
        TRK_ARMED: if (sck_rise_i && ws_i != idle_lvl) begin
          st_q   <= TRK_LOCK;
          cnt_q  <= CNT_ONE;
          prev_q <= ws_i;
        end
        TRK_LOCK: begin
          if (ws_chg) begin
            cnt_q  <= CNT_ONE;
            prev_q <= ws_i;
          end else if (sck_rise_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
          end
        end
        default: st_q <= TRK_OFF;
      endcase
    end
  end

  assign locked_o    = (st_q == TRK_LOCK);
  // change seen while locked, wrong half-frame length
  assign frame_err_o = en_i && locked_o && ws_chg && (cnt_q != len_sel);
endmodule

// File: rtl/i2s_flag_bank.sv
module i2s_flag_bank (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_load_i,
  input  logic tx_take_i,
  input  logic rx_push_i,
  input  logic rx_read_i,
  input  logic stat_rd_i,
  input  logic frame_err_i,
  output logic txe_o,
  output logic rxne_o,
  output logic udr_o,
  output logic ovr_o,
  output logic fre_o
);
  logic txe_q, rxne_q, udr_q, ovr_q, fre_q;
  logic udr_arm_q, ovr_arm_q;
  logic udr_set, ovr_set;

  assign udr_set = tx_take_i && txe_q;
  assign ovr_set = rx_push_i && rxne_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txe_q     <= 1'b1;
      rxne_q    <= 1'b0;
      udr_q     <= 1'b0;
      ovr_q     <= 1'b0;
      fre_q     <= 1'b0;
      udr_arm_q <= 1'b0;
      ovr_arm_q <= 1'b0;
    end else begin
      if (tx_load_i)      txe_q <= 1'b0;
      else if (tx_take_i) txe_q <= 1'b1;

      if (rx_push_i)      rxne_q <= 1'b1;
      else if (rx_read_i) rxne_q <= 1'b0;

      if (udr_set) begin
        udr_q     <= 1'b1;
        udr_arm_q <= 1'b0;
      end else if (udr_arm_q && tx_load_i) begin
        udr_q     <= 1'b0;
        udr_arm_q <= 1'b0;
      end else if (stat_rd_i && udr_q) begin
        udr_arm_q <= 1'b1;
      end

      if (ovr_set) begin
        ovr_q     <= 1'b1;
        ovr_arm_q <= 1'b0;
      end else if (ovr_arm_q && rx_read_i) begin
        ovr_q     <= 1'b0;
        ovr_arm_q <= 1'b0;
      end else if (stat_rd_i && ovr_q) begin
        ovr_arm_q <= 1'b1;
      end

      if (frame_err_i)    fre_q <= 1'b1;
      else if (stat_rd_i) fre_q <= 1'b0;
    end
  end

  assign txe_o  = txe_q;
  assign rxne_o = rxne_q;
  assign udr_o  = udr_q;
  assign ovr_o  = ovr_q;
  assign fre_o  = fre_q;
endmodule

// File: rtl/i2s_irq_merge.sv
module i2s_irq_merge #(
  parameter int N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] ena_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(src_i & ena_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/i2s_sync_guard.sv
module i2s_sync_guard #(
  parameter int CNT_W     = 6,
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] std_i,
  input  logic       chlen32_i,
  input  logic       sck_rise_i,
  input  logic       ws_i,
  input  logic       tx_load_i,
  input  logic       tx_take_i,
  input  logic       rx_push_i,
  input  logic       rx_read_i,
  input  logic       stat_rd_i,
  input  logic       ie_txe_i,
  input  logic       ie_rxne_i,
  input  logic       ie_err_i,
  output logic       locked_o,
  output logic       txe_o,
  output logic       rxne_o,
  output logic       udr_o,
  output logic       ovr_o,
  output logic       fre_o,
  output logic       irq_o
);
  localparam int N_SRC = 3;

  logic             frame_err;
  logic [N_SRC-1:0] irq_src;
  logic [N_SRC-1:0] irq_ena;

  i2s_ws_tracker #(
    .CNT_W(CNT_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
  ) u_trk (
    .clk_i, .rst_ni, .en_i, .std_i, .chlen32_i, .sck_rise_i, .ws_i,
    .locked_o, .frame_err_o(frame_err)
  );

  i2s_flag_bank u_flags (
    .clk_i, .rst_ni, .tx_load_i, .tx_take_i, .rx_push_i, .rx_read_i,
    .stat_rd_i, .frame_err_i(frame_err),
    .txe_o, .rxne_o, .udr_o, .ovr_o, .fre_o
  );

  assign irq_src = {udr_o | ovr_o | fre_o, rxne_o, txe_o};
  assign irq_ena = {ie_err_i, ie_rxne_i, ie_txe_i};

  i2s_irq_merge #(.N_SRC(N_SRC)) u_irq (
    .clk_i, .rst_ni, .src_i(irq_src), .ena_i(irq_ena), .irq_o
  );
endmodule

// File: rtl/i2s_sync_guard_chk.sv
module i2s_sync_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sck_rise_i,
  input logic tx_load_i,
  input logic tx_take_i,
  input logic rx_push_i,
  input logic stat_rd_i,
  input logic ie_txe_i,
  input logic ie_rxne_i,
  input logic ie_err_i,
  input logic locked_o,
  input logic txe_o,
  input logic rxne_o,
  input logic udr_o,
  input logic ovr_o,
  input logic fre_o,
  input logic irq_o
);
  AST_LOCK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !locked_o); // R2
  AST_FRE_ONLY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fre_o && !locked_o) |=> !fre_o); // R10
  AST_FRE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fre_o && stat_rd_i && !sck_rise_i) |=> !fre_o); // R4
  AST_TXE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> !txe_o); // R5
  AST_RXNE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i |=> rxne_o); // R6
  AST_UDR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_take_i && txe_o) |=> udr_o); // R7
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rxne_o) |=> ovr_o); // R8
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_txe_i && !ie_rxne_i && !ie_err_i) |=> !irq_o); // R9
endmodule

bind i2s_sync_guard i2s_sync_guard_chk u_chk (
  .clk_i, .rst_ni, .en_i, .sck_rise_i, .tx_load_i, .tx_take_i, .rx_push_i,
  .stat_rd_i, .ie_txe_i, .ie_rxne_i, .ie_err_i, .locked_o, .txe_o, .rxne_o,
  .udr_o, .ovr_o, .fre_o, .irq_o
);

// File: tb/i2s_sync_guard_bench.sv
module i2s_sync_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, chlen32 = 0, sck = 0, ws = 0;
  logic [1:0] std_sel = 2'b00;
  logic tx_load = 0, tx_take = 0, rx_push = 0, rx_read = 0, stat_rd = 0;
  logic ie_txe = 0, ie_rxne = 0, ie_err = 0;
  logic locked, txe, rxne, udr, ovr, fre, irq;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_sync_guard u_i2s_sync_guard (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .std_i(std_sel), .chlen32_i(chlen32),
    .sck_rise_i(sck), .ws_i(ws), .tx_load_i(tx_load), .tx_take_i(tx_take),
    .rx_push_i(rx_push), .rx_read_i(rx_read), .stat_rd_i(stat_rd),
    .ie_txe_i(ie_txe), .ie_rxne_i(ie_rxne), .ie_err_i(ie_err),
    .locked_o(locked), .txe_o(txe), .rxne_o(rxne), .udr_o(udr), .ovr_o(ovr),
    .fre_o(fre), .irq_o(irq)
  );

  // behavioural reference model
  int  m_st, m_cnt;
  bit  m_prev, m_txe, m_rxne, m_udr, m_ovr, m_fre, m_irq, m_uarm, m_oarm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_prev = 0;
      m_txe = 1; m_rxne = 0; m_udr = 0; m_ovr = 0; m_fre = 0; m_irq = 0;
      m_uarm = 0; m_oarm = 0;
    end else begin
      bit idle, fe, us, os;
      int len;
      idle = (std_sel == 2'b00);
      len  = chlen32 ? 32 : 16;
      fe   = 0;
      m_irq = (m_txe && ie_txe) || (m_rxne && ie_rxne) ||
              ((m_udr || m_ovr || m_fre) && ie_err);
      if (!en) begin
        m_st = 0; m_cnt = 0;
      end else if (m_st == 0) m_st = 1;
      else if (m_st == 1) begin
        if (sck && ws == idle) m_st = 2;
      end else if (m_st == 2) begin
        if (sck && ws != idle) begin m_st = 3; m_cnt = 1; m_prev = ws; end
      end else if (sck) begin
        if (ws != m_prev) begin
          fe = (m_cnt != len); m_cnt = 1; m_prev = ws;
        end else if (m_cnt < 63) m_cnt++;
      end
      us = tx_take && m_txe;
      os = rx_push && m_rxne;
      if (tx_load) m_txe = 0; else if (tx_take) m_txe = 1;
      if (rx_push) m_rxne = 1; else if (rx_read) m_rxne = 0;
      if (us) begin m_udr = 1; m_uarm = 0; end
      else if (m_uarm && tx_load) begin m_udr = 0; m_uarm = 0; end
      else if (stat_rd && m_udr) m_uarm = 1;
      if (os) begin m_ovr = 1; m_oarm = 0; end
      else if (m_oarm && rx_read) begin m_ovr = 0; m_oarm = 0; end
      else if (stat_rd && m_ovr) m_oarm = 1;
      if (fe) m_fre = 1; else if (stat_rd) m_fre = 0;
    end
  end

  task automatic chk(string req, logic act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // compared on every falling edge
  always @(negedge clk) begin
    chk("R1/R2 locked", locked, m_st == 3);
    chk("R5 txe",  txe,  m_txe);
    chk("R6 rxne", rxne, m_rxne);
    chk("R7 udr",  udr,  m_udr);
    chk("R8 ovr",  ovr,  m_ovr);
    chk("R3 fre",  fre,  m_fre);
    chk("R9 irq",  irq,  m_irq);
  end

  task automatic clr();
    sck = 0; tx_load = 0; tx_take = 0; rx_push = 0; rx_read = 0; stat_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); clr(); end
  endtask

  task automatic half(bit v, int n);
    repeat (n) begin
      @(negedge clk); clr(); sck = 1; ws = v;
      @(negedge clk); clr();
    end
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); clr(); s = 1;
    @(negedge clk); clr();
  endtask

  task automatic run();
    idle(3);
    chk("R5 reset txe", txe, 1'b1);
    chk("R6 reset rxne", rxne, 1'b0);
    chk("R9 reset irq", irq, 1'b0);
    rst_n = 1;
    idle(2);

    // R1 Philips: WS low first is not idle, no lock
    @(negedge clk); en = 1; std_sel = 2'b00; chlen32 = 0;
    half(0, 5);
    chk("R1 no lock before idle level", locked, 1'b0);
    half(1, 4);
    chk("R1 still waiting at idle level", locked, 1'b0);
    half(0, 16); half(1, 16); half(0, 16);
    chk("R1 locked Philips", locked, 1'b1);
    chk("R3 clean frames", fre, 1'b0);
    half(1, 15);
    half(0, 1);
    chk("R3 short half-frame flagged", fre, 1'b1);
    chk("R2 stays locked after error", locked, 1'b1);
    strobe(stat_rd);
    chk("R4 fre cleared by status read", fre, 1'b0);

    // R2/R10 disable, WS noise ignored
    @(negedge clk); en = 0;
    idle(1);
    chk("R2 unlock on disable", locked, 1'b0);
    half(1, 3); half(0, 2); half(1, 7);
    chk("R10 no error while unlocked", fre, 1'b0);

    // MSB-justified, 32-bit channels
    @(negedge clk); en = 1; std_sel = 2'b01; chlen32 = 1;
    half(1, 3); half(0, 2);
    half(1, 32); half(0, 32); half(1, 32);
    chk("R1 locked MSB", locked, 1'b1);
    chk("R3 clean 32-bit frames", fre, 1'b0);
    half(0, 16); half(1, 1);
    chk("R3 16 samples under 32 flagged", fre, 1'b1);
    strobe(stat_rd);

    // PCM: idle low
    @(negedge clk); en = 0; idle(1);
    @(negedge clk); en = 1; std_sel = 2'b11; chlen32 = 0;
    half(1, 4);
    chk("R1 PCM high is not idle", locked, 1'b0);
    half(0, 2); half(1, 1);
    chk("R1 locked PCM", locked, 1'b1);

    // R5..R8 flag sequences
    ie_txe = 1;
    strobe(tx_take);
    chk("R7 underrun on take while empty", udr, 1'b1);
    strobe(tx_load);
    chk("R7 load alone keeps underrun", udr, 1'b1);
    strobe(stat_rd); strobe(tx_load);
    chk("R7 read then load clears underrun", udr, 1'b0);
    strobe(rx_push); strobe(rx_push);
    chk("R8 overrun on double push", ovr, 1'b1);
    strobe(stat_rd); strobe(rx_push);
    chk("R8 new overrun cancels pending clear", ovr, 1'b1);
    strobe(rx_read);
    chk("R8 read without status read keeps ovr", ovr, 1'b1);
    strobe(stat_rd); strobe(rx_read);
    chk("R8 cleared", ovr, 1'b0);
    ie_err = 1; ie_rxne = 1;
    idle(3);

    // random phase with collisions
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      clr();
      sck     = ($urandom % 3) == 0;
      if (($urandom % 9) == 0) ws = ~ws;
      tx_load = ($urandom % 6) == 0;
      tx_take = ($urandom % 6) == 0;
      rx_push = ($urandom % 6) == 0;
      rx_read = ($urandom % 6) == 0;
      stat_rd = ($urandom % 7) == 0;
      if (($urandom % 50) == 0) begin
        ie_txe = $urandom; ie_rxne = $urandom; ie_err = $urandom;
      end
      if (($urandom % 400) == 0) en = ~en;
      if (($urandom % 700) == 0) begin std_sel = 2'($urandom); chlen32 = $urandom; end
    end
    idle(4);
  endtask

  initial begin
    bit timed_out;
    timed_out = 0;
    fork
      run();
      begin repeat (WATCHDOG) @(posedge clk); timed_out = 1; end
    join_any
    if (timed_out) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule